// File: doc/BRIEF.md
# Tick Timer with Match Modes

This block is a per-processor tick timer. It holds a free-running up-counter and a control word. The control word carries a period field, an interrupt enable, a sticky interrupt-pending flag and a two-bit mode. The counter moves forward by one on each pulse of `tick_i`, which is a one-cycle strobe from a fixed timebase (nominally 20 MHz). It only counts while the timer is running. The timer starts on `start_i` and stops on `stop_i`.

A match happens on a tick, while the timer runs, when the counter's low `PER_W` bits already equal the period field. The upper counter bits take no part in the compare. What the match does depends on the mode:

- disabled: no counter action
- restart: the counter clears to zero
- single-shot: the counter holds and the timer stops
- continuous: the counter keeps counting and wraps

With the interrupt enable set, a match also raises the pending flag, and the interrupt output goes high.

Software reads and writes both words through a plain select/write/data port. Writes take effect on the next clock edge. The read data follows `reg_sel_i` combinationally. The port carries no stream traffic, so there is no valid/ready handshake and no back-pressure.

Top module: `tick_timer`

## Requirements
- R1: After reset the counter reads 0, the control word reads 0, the timer is stopped and `irq_o` is 0.
- R2: While running, each cycle with `tick_i` high and no match action adds one to the counter, modulo 2^CNT_W.
- R3: While stopped, ticks leave the counter unchanged and never produce a match, so the pending flag is not raised.
- R4: A match is a running tick whose counter value, before the increment, has its low PER_W bits equal to the period field (control bits PER_W-1:0); counter bits above PER_W-1 are ignored.
- R5: In restart mode (control bits PER_W+3:PER_W+2 = 01), a match loads the counter with 0.
- R6: In single-shot mode (10), a match holds the counter at its matched value and stops the timer until `start_i`.
- R7: In continuous mode (11), a match leaves the counter incrementing and wrapping as in R2.
- R8: In disabled mode (00), a match takes no counter action, and the counter increments as in R2.
- R9: A match with the interrupt enable (control bit PER_W+1) at 1 sets the pending flag (control bit PER_W); with the enable at 0 it does not.
- R10: The pending flag is sticky. A control write with bit PER_W = 0 clears it, a write with that bit at 1 cannot set it, and a match in the same cycle as a clearing write leaves it set.
- R11: `irq_o` equals pending AND enable.
- R12: A counter write (`reg_sel_i` = 0) in the same cycle as a tick loads the written value, and the increment is lost.
- R13: `stop_i` stops the timer and wins over a simultaneous `start_i`; `start_i` alone starts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle timebase strobe |
| start_i | input | 1 | Start counting |
| stop_i | input | 1 | Stop counting |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects the counter, 1 selects the control word |
| reg_wdata_i | input | CNT_W | Write data |
| reg_rdata_o | output | CNT_W | Read data of the selected register |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps every period value of a small configuration (8-bit counter, 4-bit period) through each mode.

- **Restart mode.** The expected count is the tick count modulo period+1. A design that cleared one tick late or early would drift from that.
- **Single-shot mode.** A design that did not stop the timer would run past the period value.
- **Continuous mode.** The checks cover the wrap past the counter's top value, and place the pending rise exactly on the tick taken at the period value. An off-by-one compare would show up there.
- **Narrow compare.** Preloading the counter with upper bits set exposes a compare that looks at more than the period bits.
- **Same-cycle collisions.** Targeted checks cover a tick against a counter write, start against stop, and a match against a clearing write. A wrong priority would lose the write, restart a stopped timer, or drop a pending interrupt.

// File: rtl/tick_pkg.sv
package tick_pkg;
  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_RESTART = 2'b01,
    MODE_SHOT    = 2'b10,
    MODE_CONT    = 2'b11
  } tick_mode_e;
endpackage

// File: rtl/tick_count_reg.sv
module tick_count_reg #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             clr_en,
  input  logic             inc_en,
  output logic [CNT_W-1:0] cnt
);
  // Software write first, then match clear, then the tick increment.
  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (wr_en)  cnt <= wr_data;
    else if (clr_en) cnt <= '0;
    else if (inc_en) cnt <= cnt + CNT_W'(1);
  end

  p_wr_prio_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cnt == $past(wr_data));
endmodule

// File: rtl/tick_mode_reg.sv
module tick_mode_reg
  import tick_pkg::*;
#(
  parameter int PER_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PER_W-1:0] wr_period,
  input  logic             wr_pend,
  input  logic             wr_ie,
  input  tick_mode_e       wr_mode,
  input  logic             set_pend,
  output logic [PER_W-1:0] period,
  output logic             pend,
  output logic             ie,
  output tick_mode_e       mode
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period <= '0;
      ie     <= 1'b0;
      mode   <= MODE_OFF;
    end else if (wr_en) begin
      period <= wr_period;
      ie     <= wr_ie;
      mode   <= wr_mode;
    end
  end

  // Sticky flag: hardware set beats a software clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)                  pend <= 1'b0;
    else if (set_pend)           pend <= 1'b1;
    else if (wr_en && !wr_pend)  pend <= 1'b0;
  end

  p_set_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_pend |=> pend);
  p_pend_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !(wr_en && !wr_pend)) |=> pend);
  p_pend_no_sw_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !set_pend) |=> !pend);
endmodule

// File: rtl/tick_run_ctrl.sv
module tick_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  input  logic shot_hit,
  output logic running
);
  always_ff @(posedge clk) begin
    if (!rst_n)        running <= 1'b0;
    else if (stop)     running <= 1'b0;
    else if (start)    running <= 1'b1;
    else if (shot_hit) running <= 1'b0;
  end

  p_stop_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !running);
  p_shot_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shot_hit && !start) |=> !running);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PER_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             reg_wr_i,
  input  logic             reg_sel_i,
  input  logic [CNT_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0] reg_rdata_o,
  output logic             irq_o
);
  localparam int FIELD_W = PER_W + 4;
  localparam int PAD_W   = CNT_W - FIELD_W;
  localparam int IP_BIT  = PER_W;
  localparam int IE_BIT  = PER_W + 1;
  localparam int MD_LSB  = PER_W + 2;

  logic [CNT_W-1:0] cnt;
  logic [PER_W-1:0] period;
  logic             pend, ie, running;
  tick_mode_e       mode;
  logic             cnt_wr, ctl_wr, match, shot_hit, clr_en, inc_en;
  logic [FIELD_W-1:0] ctl_fields;
  logic [CNT_W-1:0]   ctl_word;

  assign cnt_wr   = reg_wr_i && !reg_sel_i;
  assign ctl_wr   = reg_wr_i &&  reg_sel_i;

  // Compare only the period-width low bits of the pre-increment count.
  assign match    = running && tick_i && (cnt[PER_W-1:0] == period);
  assign shot_hit = match && (mode == MODE_SHOT);
  assign clr_en   = match && (mode == MODE_RESTART);
  assign inc_en   = running && tick_i && !shot_hit;

  tick_count_reg #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .wr_en(cnt_wr), .wr_data(reg_wdata_i),
    .clr_en(clr_en), .inc_en(inc_en), .cnt(cnt)
  );

  tick_mode_reg #(.PER_W(PER_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr),
    .wr_period(reg_wdata_i[PER_W-1:0]),
    .wr_pend(reg_wdata_i[IP_BIT]),
    .wr_ie(reg_wdata_i[IE_BIT]),
    .wr_mode(tick_mode_e'(reg_wdata_i[MD_LSB+1:MD_LSB])),
    .set_pend(match && ie),
    .period(period), .pend(pend), .ie(ie), .mode(mode)
  );

  tick_run_ctrl u_run (
    .clk(clk), .rst_n(rst_n), .start(start_i), .stop(stop_i),
    .shot_hit(shot_hit), .running(running)
  );

  assign ctl_fields = {mode, ie, pend, period};

  generate
    if (PAD_W > 0) begin : g_pad
      assign ctl_word = {{PAD_W{1'b0}}, ctl_fields};
    end else begin : g_nopad
      assign ctl_word = ctl_fields;
    end
  endgenerate

  assign reg_rdata_o = reg_sel_i ? ctl_word : cnt;
  assign irq_o       = pend && ie;

  p_stopped_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !cnt_wr) |=> $stable(cnt));
  p_stopped_no_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !pend) |=> !pend);
  p_restart_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (match && mode == MODE_RESTART && !cnt_wr) |=> cnt == '0);
  p_cont_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (match && mode == MODE_CONT && !cnt_wr) |=> cnt == $past(cnt) + CNT_W'(1));
  p_irq_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && ie) |-> irq_o);
endmodule

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;
  localparam int CW = 8;
  localparam int PW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, start = 0, stop = 0, wr = 0, sel = 0;
  logic [CW-1:0] wdata = '0, rdata;
  logic irq;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tick_timer #(.CNT_W(CW), .PER_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .start_i(start), .stop_i(stop),
    .reg_wr_i(wr), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [CW-1:0] ctl(input int md, input int ie_b, input int ip_b, input int per);
    return {md[1:0], ie_b[0], ip_b[0], per[3:0]};
  endfunction

  task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clk1();
    @(posedge clk); #1;
    tick = 0; start = 0; stop = 0; wr = 0;
  endtask

  task automatic wr_reg(input logic s, input logic [CW-1:0] d);
    wr = 1; sel = s; wdata = d; clk1();
  endtask

  task automatic rd(input logic s, output logic [CW-1:0] v);
    sel = s; #1; v = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin tick = 1; clk1(); end
  endtask

  task automatic do_start(); start = 1; clk1(); endtask
  task automatic do_stop();  stop = 1;  clk1(); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] v;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    // R1 reset state
    rd(0, v); chk("R1 counter", v, 0);
    rd(1, v); chk("R1 control", v, 0);
    chk("R1 irq", {7'b0, irq}, 0);
    ticks(5); rd(0, v); chk("R1 stopped after reset", v, 0);

    // R5 restart sweep: count = N mod (P+1)
    for (int p = 0; p < 16; p++) begin
      wr_reg(0, 0); wr_reg(1, ctl(1, 0, 0, p)); do_start();
      ticks(37);
      rd(0, v); chk("R5 restart count", v, CW'(37 % (p + 1)));
      do_stop();
    end

    // R7/R9/R11/R2 continuous sweep with wrap
    for (int p = 0; p < 16; p++) begin
      wr_reg(0, 0); wr_reg(1, ctl(3, 1, 0, p)); do_start();
      ticks(p);
      rd(1, v); chk("R9 no pend before match", {7'b0, v[PW]}, 0);
      chk("R11 irq low before match", {7'b0, irq}, 0);
      ticks(1);
      rd(1, v); chk("R9 pend on match tick", {7'b0, v[PW]}, 1);
      chk("R11 irq on match", {7'b0, irq}, 1);
      rd(0, v); chk("R7 continues past match", v, CW'(p + 1));
      ticks(250);
      rd(0, v); chk("R2 wrap count", v, CW'((p + 251) % 256));
      do_stop(); wr_reg(1, ctl(3, 1, 0, p));
      rd(1, v); chk("R10 clear by write 0", {7'b0, v[PW]}, 0);
    end

    // R6 single-shot sweep
    for (int p = 0; p < 16; p++) begin
      wr_reg(0, 0); wr_reg(1, ctl(2, 1, 0, p)); do_start();
      ticks(p + 6);
      rd(0, v); chk("R6 held at period", v, CW'(p));
      rd(1, v); chk("R6 pend after shot", {7'b0, v[PW]}, 1);
      ticks(3); rd(0, v); chk("R6 stays stopped", v, CW'(p));
      wr_reg(0, 0); do_start(); ticks(1);
      rd(0, v); chk("R6 restarts on start", v, (p == 0) ? CW'(0) : CW'(1));
      do_stop();
    end

    // R8 disabled mode
    wr_reg(0, 0); wr_reg(1, ctl(0, 0, 0, 3)); do_start();
    ticks(20); rd(0, v); chk("R8 no counter action", v, 20);
    rd(1, v); chk("R9 no pend with enable off", {7'b0, v[PW]}, 0);
    wr_reg(0, 3); wr_reg(1, ctl(0, 1, 0, 3)); ticks(1);
    rd(0, v); chk("R8 increments through match", v, 4);
    rd(1, v); chk("R9 disabled mode still flags", {7'b0, v[PW]}, 1);
    do_stop(); wr_reg(1, ctl(0, 0, 0, 3));

    // R4 upper bits ignored
    wr_reg(0, 8'h35); wr_reg(1, ctl(3, 1, 0, 5)); do_start(); ticks(1);
    rd(1, v); chk("R4 upper bits ignored", {7'b0, v[PW]}, 1);
    rd(0, v); chk("R4 count after match", v, 8'h36);

    // R10 match beats clearing write; writing 1 does not set
    wr_reg(1, ctl(3, 1, 0, 5));
    wr_reg(0, 8'h45);
    tick = 1; wr = 1; sel = 1; wdata = ctl(3, 1, 0, 5); clk1();
    rd(1, v); chk("R10 set wins over clear", {7'b0, v[PW]}, 1);
    wr_reg(1, ctl(3, 0, 1, 5));
    rd(1, v); chk("R10 write 1 keeps pend", {7'b0, v[PW]}, 1);
    chk("R11 irq masked by enable", {7'b0, irq}, 0);
    wr_reg(1, ctl(3, 0, 0, 5));
    wr_reg(1, ctl(3, 1, 1, 5));
    rd(1, v); chk("R10 write 1 cannot set", {7'b0, v[PW]}, 0);

    // R12 write priority over tick
    tick = 1; wr = 1; sel = 0; wdata = 8'h80; clk1();
    rd(0, v); chk("R12 write beats tick", v, 8'h80);

    // R3 stopped: hold, no match
    wr_reg(0, 8'h05); do_stop(); ticks(10);
    rd(0, v); chk("R3 hold while stopped", v, 8'h05);
    rd(1, v); chk("R3 no match while stopped", {7'b0, v[PW]}, 0);

    // R13 stop wins over start
    start = 1; stop = 1; clk1(); ticks(4);
    rd(0, v); chk("R13 stop wins", v, 8'h05);
    do_start(); wr_reg(1, ctl(3, 0, 0, 0)); ticks(4);
    rd(0, v); chk("R13 start alone runs", v, 8'h09);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule